// File: doc/BRIEF.md
# Doorbell Interrupt Aggregator

This block holds a set of doorbell flags for each processor in a cluster. Both processors and bus masters raise these flags. One shared trigger port takes a word that names a doorbell and a set of target processors. A single write raises the same doorbell in every processor the word selects. This serves as an inter-processor interrupt path, and it also lets a bus master deliver message-signalled interrupts.

Each processor has its own pending (cause) register and its own enable (mask) register. Software clears pending flags by writing zeros into the cause register; bits written as one keep their value. For each processor, the pending flags that are enabled are folded into two summary lines, low and high, which feed the two lowest sources of a main interrupt controller.

A mode input decides how the doorbells are grouped:
- **Inter-processor mode:** a small low range of doorbells serves as processor-to-processor doorbells and drives the low summary. The upper half of the doorbells drives the high summary. The doorbells between these two ranges are stored but drive neither summary.
- **MSI-only mode:** the lower half of the doorbells drives the low summary and the upper half drives the high summary.

Top module: `doorbell_unit`

## Requirements
- R1: Reset clears every cause and mask bit of every processor, so all reads return zero and every summary output is low.
- R2: A trigger write uses its data word as follows. Bits 4:0 give the doorbell index, and bit 8+c selects processor c. The write sets that doorbell bit in the cause register of every selected processor and leaves unselected processors unchanged.
- R3: A cause-register write (regSel = 0) clears each cause bit that is written as 0 and leaves each bit written as 1 unchanged.
- R4: A mask-register write (regSel = 1) replaces the mask of the selected processor. A mask bit of 1 enables its doorbell, and a mask bit of 0 keeps it out of both summaries.
- R5: When a trigger write sets a cause bit in the same cycle that a cause write clears that bit, the bit ends up set.
- R6: In inter-processor mode (ipiMode = 1), sumLo[c] is high exactly when one of doorbells 0 to 7 is both pending and enabled for processor c. sumHi[c] is high exactly when one of doorbells 16 to 31 is both pending and enabled.
- R7: In MSI-only mode (ipiMode = 0), sumLo[c] covers doorbells 0 to 15 and sumHi[c] covers doorbells 16 to 31.
- R8: In inter-processor mode, doorbells 8 to 15 can be set and cleared, but they drive neither summary output.
- R9: rdData shows, without a clock delay, the cause register (regSel = 0) or the mask register (regSel = 1) of the processor selected by cpuSel. A write takes effect at the clock edge where it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ipiMode | input | 1 | 1: inter-processor grouping, 0: MSI-only grouping |
| trigValid | input | 1 | Trigger write strobe |
| trigData | input | 32 | Trigger word: doorbell index in the low bits, target bitmap from bit 8 |
| regWrite | input | 1 | Per-processor register write strobe |
| regSel | input | 1 | 0 selects the cause register, 1 selects the mask register |
| cpuSel | input | 1 | Processor whose register is accessed |
| regWdata | input | 32 | Write data for the per-processor register |
| rdData | output | 32 | Read data of the selected register |
| sumLo | output | NCPU | Low summary line, one per processor |
| sumHi | output | NCPU | High summary line, one per processor |

## Verification
A cause bit set or cleared wrongly shows on rdData in the first cycle after the write edge, and on a summary line in that same cycle if the bit is enabled. A mask held wrongly, or a group boundary placed wrongly, shows as a summary line that disagrees with the enabled pending bits. The reference model therefore compares both summary lines of every processor on every clock. A wrong set-versus-clear priority only shows when both strobes hit the same bit in one cycle, so the bench drives that collision on purpose.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  // strobes handed from control to datapath for one processor
  typedef struct packed {
    logic setHit;   // trigger write targets this processor
    logic causeWr;  // clear-by-zero write to the cause register
    logic maskWr;   // overwrite of the mask register
  } cpuStrobeT;

  typedef enum logic {
    SEL_CAUSE = 1'b0,
    SEL_MASK  = 1'b1
  } regSelT;

endpackage

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int NCPU    = 2,
  parameter int DBW     = 32,
  parameter int TGT_LSB = 8
) (
  input  logic                              trigValid,
  input  logic [DBW-1:0]                    trigData,
  input  logic                              regWrite,
  input  logic                              regSel,
  input  logic [(NCPU>1?$clog2(NCPU):1)-1:0] cpuSel,
  output cpuStrobeT [NCPU-1:0]              strobes,
  output logic [DBW-1:0]                    setVec
);

  localparam int IDXW = $clog2(DBW);
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic [IDXW-1:0] dbIdx;
  logic [NCPU-1:0] targets;
  logic            unusedTrig;

  assign dbIdx      = trigData[IDXW-1:0];
  assign targets    = trigData[TGT_LSB +: NCPU];
  assign unusedTrig = ^trigData;

  // one-hot decode of the doorbell being raised
  always_comb begin
    setVec = '0;
    setVec[dbIdx] = 1'b1;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic hitCpu;
    assign hitCpu             = (cpuSel == CPUW'(c));
    assign strobes[c].setHit  = trigValid & targets[c];
    assign strobes[c].causeWr = regWrite & hitCpu & (regSelT'(regSel) == SEL_CAUSE);
    assign strobes[c].maskWr  = regWrite & hitCpu & (regSelT'(regSel) == SEL_MASK);
  end

endmodule

// File: rtl/doorbell_datapath.sv
module doorbell_datapath
  import doorbell_pkg::*;
#(
  parameter int NCPU      = 2,
  parameter int DBW       = 32,
  parameter int IPI_COUNT = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ipiMode,
  input  cpuStrobeT [NCPU-1:0]              strobes,
  input  logic [DBW-1:0]                    setVec,
  input  logic [DBW-1:0]                    regWdata,
  input  logic                              regSel,
  input  logic [(NCPU>1?$clog2(NCPU):1)-1:0] cpuSel,
  output logic [NCPU-1:0][DBW-1:0]          causeArr,
  output logic [NCPU-1:0][DBW-1:0]          maskArr,
  output logic [DBW-1:0]                    rdData,
  output logic [NCPU-1:0]                   sumLo,
  output logic [NCPU-1:0]                   sumHi
);

  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int HALF = DBW / 2;
  localparam logic [DBW-1:0] LO_MSI_GRP = {{HALF{1'b0}}, {HALF{1'b1}}};
  localparam logic [DBW-1:0] LO_IPI_GRP = {{(DBW-IPI_COUNT){1'b0}}, {IPI_COUNT{1'b1}}};
  localparam logic [DBW-1:0] HI_GRP     = ~LO_MSI_GRP;

  logic [DBW-1:0] loGrp;
  assign loGrp = ipiMode ? LO_IPI_GRP : LO_MSI_GRP;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [DBW-1:0] causeQ, maskQ, causeNext, live;

    // clear-by-zero first, then the trigger set on top so that it wins
    always_comb begin
      causeNext = causeQ;
      if (strobes[c].causeWr) causeNext = causeNext & regWdata;
      if (strobes[c].setHit)  causeNext = causeNext | setVec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        causeQ <= '0;
        maskQ  <= '0;
      end else begin
        causeQ <= causeNext;
        if (strobes[c].maskWr) maskQ <= regWdata;
      end
    end

    assign live        = causeQ & maskQ;
    assign sumLo[c]    = |(live & loGrp);
    assign sumHi[c]    = |(live & HI_GRP);
    assign causeArr[c] = causeQ;
    assign maskArr[c]  = maskQ;
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (cpuSel == CPUW'(c))
        rdData = (regSelT'(regSel) == SEL_MASK) ? maskArr[c] : causeArr[c];
    end
  end

endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import doorbell_pkg::*;
#(
  parameter int NCPU      = 2,
  parameter int DBW       = 32,
  parameter int IPI_COUNT = 8,
  parameter int TGT_LSB   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ipiMode,
  input  logic                              trigValid,
  input  logic [DBW-1:0]                    trigData,
  input  logic                              regWrite,
  input  logic                              regSel,
  input  logic [(NCPU>1?$clog2(NCPU):1)-1:0] cpuSel,
  input  logic [DBW-1:0]                    regWdata,
  output logic [DBW-1:0]                    rdData,
  output logic [NCPU-1:0]                   sumLo,
  output logic [NCPU-1:0]                   sumHi
);

  cpuStrobeT [NCPU-1:0]     strobes;
  logic [DBW-1:0]           setVec;
  logic [NCPU-1:0][DBW-1:0] causeArr;
  logic [NCPU-1:0][DBW-1:0] maskArr;

  doorbell_ctrl #(.NCPU(NCPU), .DBW(DBW), .TGT_LSB(TGT_LSB)) u_ctrl (
    .trigValid(trigValid),
    .trigData (trigData),
    .regWrite (regWrite),
    .regSel   (regSel),
    .cpuSel   (cpuSel),
    .strobes  (strobes),
    .setVec   (setVec)
  );

  doorbell_datapath #(.NCPU(NCPU), .DBW(DBW), .IPI_COUNT(IPI_COUNT)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ipiMode (ipiMode),
    .strobes (strobes),
    .setVec  (setVec),
    .regWdata(regWdata),
    .regSel  (regSel),
    .cpuSel  (cpuSel),
    .causeArr(causeArr),
    .maskArr (maskArr),
    .rdData  (rdData),
    .sumLo   (sumLo),
    .sumHi   (sumHi)
  );

endmodule

// File: rtl/doorbell_chk.sv
module doorbell_chk #(
  parameter int NCPU      = 2,
  parameter int DBW       = 32,
  parameter int IPI_COUNT = 8,
  parameter int TGT_LSB   = 8
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              ipiMode,
  input logic                              trigValid,
  input logic [DBW-1:0]                    trigData,
  input logic                              regWrite,
  input logic                              regSel,
  input logic [(NCPU>1?$clog2(NCPU):1)-1:0] cpuSel,
  input logic [DBW-1:0]                    regWdata,
  input logic [NCPU-1:0]                   sumLo,
  input logic [NCPU-1:0]                   sumHi,
  input logic [NCPU-1:0][DBW-1:0]          causeArr,
  input logic [NCPU-1:0][DBW-1:0]          maskArr
);

  localparam int IDXW = $clog2(DBW);
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int HALF = DBW / 2;
  localparam logic [DBW-1:0] UPPER = {{HALF{1'b1}}, {HALF{1'b0}}};
  localparam logic [DBW-1:0] BAND  = {{HALF{1'b0}}, {(HALF-IPI_COUNT){1'b1}}, {IPI_COUNT{1'b0}}};

  logic unusedChk;
  assign unusedChk = ^trigData;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (causeArr == '0) && (maskArr == '0));

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    // R2
    trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trigValid && trigData[TGT_LSB + c])
        |=> causeArr[c][$past(trigData[IDXW-1:0])]);

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (regWrite && !regSel && cpuSel == CPUW'(c) && !(trigValid && trigData[TGT_LSB + c]))
        |=> causeArr[c] == ($past(causeArr[c]) & $past(regWdata)));

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (regWrite && regSel && cpuSel == CPUW'(c)) |=> maskArr[c] == $past(regWdata));

    // R8
    band_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ipiMode && ((causeArr[c] & maskArr[c] & ~BAND) == '0)) |-> !sumLo[c] && !sumHi[c]);

    // R6
    hi_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((causeArr[c] & maskArr[c] & UPPER) != '0) |-> sumHi[c]);
  end

endmodule

bind doorbell_unit doorbell_chk #(
  .NCPU(NCPU), .DBW(DBW), .IPI_COUNT(IPI_COUNT), .TGT_LSB(TGT_LSB)
) u_chk (.*);

// File: tb/sim_doorbell_unit.sv
module sim_doorbell_unit;

  localparam int NCPU = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ipiMode = 1'b1;
  logic            trigValid = 1'b0;
  logic [31:0]     trigData = '0;
  logic            regWrite = 1'b0;
  logic            regSel = 1'b0;
  logic [0:0]      cpuSel = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     rdData;
  logic [NCPU-1:0] sumLo, sumHi;

  int  checks = 0;
  int  errs = 0;
  bit  done = 0;

  logic [31:0] mCause [NCPU];
  logic [31:0] mMask  [NCPU];

  always #10 clk = ~clk;

  doorbell_unit #(.NCPU(NCPU)) u0 (
    .clk(clk), .rst_n(rst_n), .ipiMode(ipiMode),
    .trigValid(trigValid), .trigData(trigData),
    .regWrite(regWrite), .regSel(regSel), .cpuSel(cpuSel),
    .regWdata(regWdata), .rdData(rdData), .sumLo(sumLo), .sumHi(sumHi)
  );

  // behavioural reference: clear-by-zero, then trigger set (set wins)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++) begin
        mCause[c] <= '0;
        mMask[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < NCPU; c++) begin
        logic [31:0] nc;
        nc = mCause[c];
        if (regWrite && int'(cpuSel) == c && !regSel) nc = nc & regWdata;
        if (trigValid && trigData[8 + c]) nc[trigData[4:0]] = 1'b1;
        mCause[c] <= nc;
        if (regWrite && int'(cpuSel) == c && regSel) mMask[c] <= regWdata;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // summary comparison on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCPU; c++) begin
        logic lo, hi;
        lo = 1'b0;
        hi = 1'b0;
        for (int b = 0; b < 32; b++) begin
          if (mCause[c][b] && mMask[c][b]) begin
            if (b >= 16) hi = 1'b1;
            else if (!ipiMode || b < 8) lo = 1'b1;
          end
        end
        chk(ipiMode ? "R6 sumLo" : "R7 sumLo", 32'(sumLo[c]), 32'(lo));
        chk(ipiMode ? "R6 sumHi" : "R7 sumHi", 32'(sumHi[c]), 32'(hi));
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #5;
    trigValid = 1'b0;
    regWrite  = 1'b0;
  endtask

  task automatic trig(int idx, logic [NCPU-1:0] map);
    trigValid = 1'b1;
    trigData  = (32'(map) << 8) | 32'(idx);
  endtask

  task automatic wr(int cpu, logic sel, logic [31:0] data);
    regWrite = 1'b1;
    cpuSel   = 1'(cpu);
    regSel   = sel;
    regWdata = data;
  endtask

  task automatic rdChk(string req, int cpu, logic sel, logic [31:0] exp);
    cpuSel = 1'(cpu);
    regSel = sel;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #4_000_000;
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    step();
    step();
    rst_n = 1'b1;
    step();

    // R1: everything cleared
    for (int c = 0; c < NCPU; c++) begin
      rdChk("R1 cause", c, 1'b0, 32'h0);
      rdChk("R1 mask", c, 1'b1, 32'h0);
    end
    chk("R1 summaries", 32'({sumLo, sumHi}), 32'h0);

    // R4: mask load
    wr(0, 1'b1, 32'hFFFF_FFFF); step();
    wr(1, 1'b1, 32'hFFFF_00FF); step();
    rdChk("R4 mask cpu0", 0, 1'b1, 32'hFFFF_FFFF);
    rdChk("R4 R9 mask cpu1", 1, 1'b1, 32'hFFFF_00FF);

    // R2: single target, then both targets
    trig(3, 2'b10); step();
    rdChk("R2 R9 cause cpu1", 1, 1'b0, 32'h0000_0008);
    rdChk("R2 cause cpu0 untouched", 0, 1'b0, 32'h0);
    chk("R6 cpu1 low line", 32'(sumLo[1]), 32'h1);
    trig(20, 2'b11); step();
    rdChk("R2 cause cpu0", 0, 1'b0, 32'h0010_0000);
    rdChk("R2 cause cpu1", 1, 1'b0, 32'h0010_0008);

    // R3: clear by zero
    wr(1, 1'b0, 32'hFFFF_FFF7); step();
    rdChk("R3 cause cpu1", 1, 1'b0, 32'h0010_0000);
    wr(0, 1'b0, 32'hFFEF_FFFF); step();
    wr(1, 1'b0, 32'h0); step();
    rdChk("R3 cause cpu0", 0, 1'b0, 32'h0);
    rdChk("R3 cause cpu1", 1, 1'b0, 32'h0);

    // R8: middle band stored but silent in inter-processor mode
    trig(10, 2'b01); step();
    rdChk("R8 cause cpu0", 0, 1'b0, 32'h0000_0400);
    chk("R8 sumLo cpu0", 32'(sumLo[0]), 32'h0);
    chk("R8 sumHi cpu0", 32'(sumHi[0]), 32'h0);

    // R7: MSI-only grouping brings the same bit onto the low line
    ipiMode = 1'b0;
    #1;
    chk("R7 sumLo cpu0", 32'(sumLo[0]), 32'h1);
    wr(0, 1'b0, 32'h0); step();
    chk("R7 sumLo cleared", 32'(sumLo[0]), 32'h0);

    // R5: set and clear collide on the same bit
    trig(5, 2'b01);
    wr(0, 1'b0, 32'h0);
    step();
    rdChk("R5 cause cpu0", 0, 1'b0, 32'h0000_0020);

    // R4: disabled doorbell stays off the line; R7 high line
    trig(12, 2'b10); step();
    chk("R4 masked bit12 cpu1", 32'(sumLo[1]), 32'h0);
    trig(31, 2'b10); step();
    chk("R7 sumHi cpu1", 32'(sumHi[1]), 32'h1);
    rdChk("R2 cause cpu1", 1, 1'b0, 32'h8000_1000);

    // R6: back to inter-processor grouping
    ipiMode = 1'b1;
    step();
    chk("R6 sumLo cpu0", 32'(sumLo[0]), 32'h1);

    step();
    finishRun();
  end

endmodule